// File: doc/BRIEF.md
# NaN Width Converter

This unit re-encodes a NaN operand between the 32-bit and 64-bit binary floating-point formats, and also handles the two cases where source and destination share a format. The payload passes through an internal canonical form. That form holds the sign and a 64-bit payload whose most significant fraction bit sits at bit 63. Widening therefore keeps every payload bit. Narrowing keeps only the upper fraction bits, and if those bits are all zero the unit returns the destination format's default NaN.

Each conversion is requested by pulsing a valid input together with the operand and two format selects. The result appears one clock later on registered outputs. Alongside it come an invalid flag, set when the source was a signaling NaN, and an error flag, set when the source was not a NaN at all. When the error flag is set, the data output carries no defined value.

A NaN here has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit is 1 and signaling when that bit is 0. Format select encoding: 0 selects the 32-bit format and 1 selects the 64-bit format. A 32-bit value travels in bits [31:0] of the 64-bit data buses.

Top module: `nanconv_unit`

## Requirements
- R1: While reset is asserted, and after it until the first accepted request, out_valid, out_invalid, out_not_nan and out_nan are all zero.
- R2: out_valid is high exactly one cycle after in_valid was high. When in_valid is low, out_nan, out_invalid and out_not_nan hold their previous values.
- R3: For a 32-bit source NaN with sign s and fraction f[22:0], a 64-bit destination gives {s, 11'h7FF, f, 29'b0}.
- R4: For a 64-bit source NaN with sign s and fraction g[51:0], a 32-bit destination gives {32'b0, s, 8'hFF, g[51:29]} when g[51:29] is nonzero.
- R5: In the R4 case, when g[51:29] is zero, the output is the 32-bit default NaN (parameter, default 32'h7FC00000 in bits [31:0], upper bits zero).
- R6: When source and destination formats are the same, a NaN source is returned unchanged (for a 32-bit source, only bits [31:0]; the upper 32 output bits are zero).
- R7: out_invalid is 1 exactly when the source is a signaling NaN (fraction MSB 0, remaining fraction bits nonzero).
- R8: A quiet source NaN gives a quiet result, and a signaling source NaN whose payload survives gives a signaling result. A signaling NaN is not silenced.
- R9: out_not_nan is 1 exactly when the source is not a NaN (zero, finite, or infinity), and out_invalid is then 0.
- R10: For a 32-bit source, in_op[63:32] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 64 | Source operand (32-bit format in [31:0]) |
| in_src_fmt | input | 1 | Source format: 0 = 32-bit, 1 = 64-bit |
| in_dst_fmt | input | 1 | Destination format: 0 = 32-bit, 1 = 64-bit |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_nan | output | 64 | Converted NaN |
| out_invalid | output | 1 | Source was a signaling NaN |
| out_not_nan | output | 1 | Source was not a NaN; out_nan undefined |

## Verification
The bench applies quiet and signaling NaNs of both signs in all four format pairings. Narrowing is driven with two kinds of payload: payloads confined to the low 29 fraction bits, which must fall back to the default NaN, and payloads with a single bit just above that cut, which must survive. Together these separate correct truncation from an off-by-one shift. Zero, finite and infinite operands show that the error flag is distinct from the invalid flag. A 32-bit source with garbage in the upper half, and a run of idle cycles with changing inputs, show that neither disturbs the result.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;
  localparam int SGL_W    = 32;
  localparam int SGL_EXP  = 8;
  localparam int SGL_FRAC = 23;
  localparam int DBL_W    = 64;
  localparam int DBL_EXP  = 11;
  localparam int DBL_FRAC = 52;
  localparam int CANON_W  = 64;
  localparam int SGL_SHIFT = CANON_W - SGL_FRAC - SGL_EXP - 1 + SGL_EXP + 1; // 41
  localparam int DBL_SHIFT = CANON_W - DBL_FRAC;                            // 12

  typedef enum logic {FMT_SGL = 1'b0, FMT_DBL = 1'b1} fmt_e;

  typedef struct packed {
    logic               sign;
    logic [CANON_W-1:0] pay;
  } canon_t;

  function automatic canon_t sgl_to_canon(input logic [SGL_W-1:0] v);
    canon_t c;
    logic [CANON_W-1:0] wide;
    wide   = {{(CANON_W-SGL_W){1'b0}}, v};
    c.sign = v[SGL_W-1];
    c.pay  = wide << SGL_SHIFT;
    return c;
  endfunction

  function automatic canon_t dbl_to_canon(input logic [DBL_W-1:0] v);
    canon_t c;
    c.sign = v[DBL_W-1];
    c.pay  = v << DBL_SHIFT;
    return c;
  endfunction

  function automatic logic [DBL_W-1:0] canon_to_sgl(input canon_t c,
                                                    input logic [SGL_W-1:0] dflt);
    logic [CANON_W-1:0] rec;
    rec = c.pay >> SGL_SHIFT;
    if (rec == '0)
      return {{(DBL_W-SGL_W){1'b0}}, dflt};
    return {{(DBL_W-SGL_W){1'b0}}, c.sign, {SGL_EXP{1'b1}}, rec[SGL_FRAC-1:0]};
  endfunction

  function automatic logic [DBL_W-1:0] canon_to_dbl(input canon_t c,
                                                    input logic [DBL_W-1:0] dflt);
    logic [CANON_W-1:0] rec;
    rec = c.pay >> DBL_SHIFT;
    if (rec == '0)
      return dflt;
    return {c.sign, {DBL_EXP{1'b1}}, rec[DBL_FRAC-1:0]};
  endfunction
endpackage

// File: rtl/nanconv_classify.sv
module nanconv_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] val,
  output logic         is_nan,
  output logic         is_qnan,
  output logic         is_snan
);
  logic exp_ones;
  logic frac_nz;
  assign exp_ones = &val[W-2:FRAC_W];
  assign frac_nz  = |val[FRAC_W-1:0];
  assign is_nan   = exp_ones && frac_nz;
  assign is_qnan  = is_nan && val[FRAC_W-1];
  assign is_snan  = is_nan && !val[FRAC_W-1];
endmodule

// File: rtl/nanconv_encode.sv
module nanconv_encode
  import nanconv_pkg::*;
(
  input  logic [DBL_W-1:0] op,
  input  fmt_e             src_fmt,
  output canon_t           canon
);
  always_comb begin
    if (src_fmt == FMT_SGL) canon = sgl_to_canon(op[SGL_W-1:0]);
    else                    canon = dbl_to_canon(op);
  end
endmodule

// File: rtl/nanconv_decode.sv
module nanconv_decode
  import nanconv_pkg::*;
#(
  parameter logic [SGL_W-1:0] DFLT_SGL = 32'h7FC0_0000,
  parameter logic [DBL_W-1:0] DFLT_DBL = 64'h7FF8_0000_0000_0000
) (
  input  canon_t           canon,
  input  fmt_e             dst_fmt,
  output logic [DBL_W-1:0] res
);
  always_comb begin
    if (dst_fmt == FMT_SGL) res = canon_to_sgl(canon, DFLT_SGL);
    else                    res = canon_to_dbl(canon, DFLT_DBL);
  end
endmodule

// File: rtl/nanconv_unit.sv
module nanconv_unit
  import nanconv_pkg::*;
#(
  parameter logic [31:0] DFLT_SGL = 32'h7FC0_0000,
  parameter logic [63:0] DFLT_DBL = 64'h7FF8_0000_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        in_src_fmt,
  input  logic        in_dst_fmt,
  output logic        out_valid,
  output logic [63:0] out_nan,
  output logic        out_invalid,
  output logic        out_not_nan
);
  localparam int NFMT = 2;

  logic [NFMT-1:0] cls_nan, cls_qnan, cls_snan;

  genvar gi;
  generate
    for (gi = 0; gi < NFMT; gi++) begin : g_cls
      if (gi == 0) begin : g_sgl
        nanconv_classify #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_cls (
          .val(in_op[SGL_W-1:0]), .is_nan(cls_nan[gi]),
          .is_qnan(cls_qnan[gi]), .is_snan(cls_snan[gi]));
      end else begin : g_dbl
        nanconv_classify #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_cls (
          .val(in_op), .is_nan(cls_nan[gi]),
          .is_qnan(cls_qnan[gi]), .is_snan(cls_snan[gi]));
      end
    end
  endgenerate

  fmt_e src_fmt, dst_fmt;
  assign src_fmt = fmt_e'(in_src_fmt);
  assign dst_fmt = fmt_e'(in_dst_fmt);

  // Named events for the checker
  logic src_is_nan, src_is_qnan, src_is_snan;
  assign src_is_nan  = cls_nan[in_src_fmt];
  assign src_is_qnan = cls_qnan[in_src_fmt];
  assign src_is_snan = cls_snan[in_src_fmt];

  canon_t      canon;
  logic [63:0] conv_res;

  nanconv_encode u_enc (.op(in_op), .src_fmt(src_fmt), .canon(canon));

  nanconv_decode #(.DFLT_SGL(DFLT_SGL), .DFLT_DBL(DFLT_DBL)) u_dec (
    .canon(canon), .dst_fmt(dst_fmt), .res(conv_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_nan     <= '0;
      out_invalid <= 1'b0;
      out_not_nan <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_nan     <= conv_res;
        out_invalid <= src_is_snan;
        out_not_nan <= !src_is_nan;
      end
    end
  end
endmodule

module nanconv_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_dst_fmt,
  input logic        out_valid,
  input logic [63:0] out_nan,
  input logic        out_invalid,
  input logic        out_not_nan,
  input logic        src_is_nan,
  input logic        src_is_qnan,
  input logic        src_is_snan
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_nan) && $stable(out_invalid) && $stable(out_not_nan)));
  assert_snan_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_invalid == $past(src_is_snan)));
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_not_nan) |-> !out_invalid);
  assert_sgl_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_is_nan && !in_dst_fmt) |=> (out_nan[63:32] == 32'h0));
  assert_dbl_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_is_nan && in_dst_fmt) |=> (out_nan[62:52] == 11'h7FF));
  assert_quiet_dbl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_is_qnan && in_dst_fmt) |=> out_nan[51]);
  assert_quiet_sgl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_is_qnan && !in_dst_fmt) |=> out_nan[22]);
endmodule

bind nanconv_unit nanconv_unit_chk u_chk (.*);

// File: tb/nanconv_unit_bench.sv
`timescale 1ns/1ps
module nanconv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        in_src_fmt = 1'b0;
  logic        in_dst_fmt = 1'b0;
  logic        out_valid;
  logic [63:0] out_nan;
  logic        out_invalid;
  logic        out_not_nan;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nanconv_unit u_nanconv_unit (.*);

  // reference state for the next compare
  logic        e_valid = 1'b0;
  logic [63:0] e_nan = '0;
  logic        e_inv = 1'b0;
  logic        e_err = 1'b0;
  string       e_tag = "R1";

  task automatic model(input logic [63:0] op, input logic sf, input logic df,
                       output logic [63:0] r, output logic inv, output logic err);
    logic s; logic isnan; logic q;
    logic [22:0] f1; logic [51:0] f2; logic [22:0] kept;
    r = '0;
    if (!sf) begin
      s = op[31]; f1 = op[22:0];
      isnan = (op[30:23] == 8'hFF) && (f1 != 0); q = f1[22];
      if (df) r = {s, 11'h7FF, f1, 29'b0};
      else    r = {32'b0, op[31:0]};
    end else begin
      s = op[63]; f2 = op[51:0];
      isnan = (op[62:52] == 11'h7FF) && (f2 != 0); q = f2[51];
      if (df) r = op;
      else begin
        kept = f2[51:29];
        if (kept == 0) r = 64'h0000_0000_7FC0_0000;
        else           r = {32'b0, s, 8'hFF, kept};
      end
    end
    inv = isnan && !q;
    err = !isnan;
  endtask

  task automatic check_now();
    n_cmp++;
    if (out_valid !== e_valid || out_invalid !== e_inv || out_not_nan !== e_err) begin
      n_bad++;
      $display("FAIL %s flags: valid/inv/err got %b%b%b expected %b%b%b", e_tag,
               out_valid, out_invalid, out_not_nan, e_valid, e_inv, e_err);
    end else if (!e_err && out_nan !== e_nan) begin
      n_bad++;
      $display("FAIL %s data: got %h expected %h", e_tag, out_nan, e_nan);
    end
  endtask

  // compare current output, then drive a new input (at negedge)
  task automatic step(input logic v, input logic [63:0] op, input logic sf,
                      input logic df, input string tag);
    logic [63:0] r; logic inv; logic err;
    @(negedge clk);
    check_now();
    in_valid = v; in_op = op; in_src_fmt = sf; in_dst_fmt = df;
    e_valid = v;
    if (v) begin
      model(op, sf, df, r, inv, err);
      e_nan = r; e_inv = inv; e_err = err;
    end
    e_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_tag = "R1"; check_now();           // R1 reset state
    rst_n = 1'b1;
    step(0, 64'h0, 0, 0, "R1");
    step(0, 64'h0, 0, 0, "R1");
    // R3 widening
    step(1, 64'h0000_0000_7FC1_2345, 0, 1, "R3");
    step(1, 64'h0000_0000_FF80_0001, 0, 1, "R3_R7");
    step(1, 64'h0000_0000_7F80_4000, 0, 1, "R8");
    // R4 narrowing with surviving payload
    step(1, 64'h7FF8_0000_0000_0001, 1, 0, "R4");
    step(1, 64'hFFF0_0000_2000_0000, 1, 0, "R4_R8");
    step(1, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, "R4");
    // R5 truncated to zero -> default NaN
    step(1, 64'h7FF0_0000_0000_0001, 1, 0, "R5");
    step(1, 64'hFFF0_0000_1FFF_FFFF, 1, 0, "R5");
    // R6 identity
    step(1, 64'h0000_0000_FFA0_0007, 0, 0, "R6");
    step(1, 64'hFFF4_5678_9ABC_DEF0, 1, 1, "R6");
    step(1, 64'h7FF8_0000_0000_0000, 1, 1, "R6");
    // R9 non-NaN sources
    step(1, 64'h0000_0000_3F80_0000, 0, 1, "R9");
    step(1, 64'h0000_0000_7F80_0000, 0, 0, "R9");
    step(1, 64'hFFF0_0000_0000_0000, 1, 0, "R9");
    step(1, 64'h0, 1, 1, "R9");
    // R10 upper garbage with 32-bit source
    step(1, 64'hDEAD_BEEF_7FC0_0001, 0, 1, "R10");
    step(1, 64'hFFFF_FFFF_7F80_0001, 0, 0, "R10");
    step(1, 64'h1234_5678_3F80_0000, 0, 0, "R10");
    // R2 hold while idle, inputs moving
    step(1, 64'h0000_0000_7FBF_FFFF, 0, 1, "R2");
    step(0, 64'hFFF0_0000_0000_0001, 1, 0, "R2");
    step(0, 64'h0000_0000_3F80_0000, 0, 1, "R2");
    step(0, 64'h1, 1, 1, "R2");
    // back-to-back mixed
    for (int i = 0; i < 16; i++) begin
      logic [63:0] op;
      op = {1'(i), 11'h7FF, 52'(64'h1 << (i * 3))};
      step(1, op, 1'(i >> 1), 1'(i >> 2), "R7");
    end
    step(0, 64'h0, 0, 0, "R2");
    step(0, 64'h0, 0, 0, "R2");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule